// File: doc/BRIEF.md
# Timer Group Bus Interface

This block sits between a CPU-side register bus and the internal bus that serves a group of timer submodules. It owns a 16-bit configuration register at the bottom of the group's address window. The register holds a stop control, a freeze-response control, a two-bit vector base and a three-bit arbitration number. The block turns the stop and freeze controls into one registered run enable that every submodule obeys.

CPU accesses above the four local slots are forwarded to the submodule bus one cycle later. Their read data is returned with the same latency as local reads. Forwarding continues while the group is stopped, so software can still reach submodule registers.

The block also collects interrupt requests from the submodules. The lowest-numbered pending submodule wins, and its level is presented to the CPU. When an acknowledge cycle names that level and this block's arbitration number, the block returns the level, the arbitration number and an 8-bit vector. The vector's upper two bits come from the configuration register and its lower six bits come from the winning submodule.

Top module: `tmr_bus_iface`

## Requirements
- R1: After reset the configuration register (offset 0) reads 0x1800: bits 12:11 (vector base) are 1 and all other bits are 0. run_en is 1 and irq_lvl_o is 0.
- R2: Only bits 15 (stop), 14 (freeze response), 12:11 (vector base), 10:8 (arbitration number), 5 and 0 hold written values. Writing 0xFFFF to offset 0 reads back 0xDF21.
- R3: Offsets 1 to 3 always read 0. Writes to them leave the configuration register unchanged.
- R4: When the stop bit is 1, run_en is 0 from the second cycle after the write cycle. It stays 0 until the stop bit is written 0 or reset occurs.
- R5: A request to an address of 4 or more appears on sub_sel/sub_wr/sub_addr/sub_wdata in the cycle after the request cycle, whatever the stop bit is. The sub_rdata of that cycle is returned on reg_rdata.
- R6: With the freeze-response bit at 1, a 1 on freeze sampled at a clock edge makes run_en 0 after that edge. With the bit at 0, freeze has no effect on run_en.
- R7: The acknowledge vector is {vector base bits, 6-bit code of the winning submodule}, giving bases 0x00, 0x40, 0x80 and 0xC0. It uses the base value held before the clock edge at which the acknowledge is sampled.
- R8: When several submodules request at once, the lowest-numbered one supplies the level on irq_lvl_o (registered, one cycle after the request) and the vector code. irq_lvl_o is 0 when nothing is pending.
- R9: An acknowledge is answered in the next cycle (iack_resp=1 with level, arbitration number and vector) only when its level equals the nonzero level of the winning request and its arbitration number equals the register's. In every other case iack_resp is 0 and the response outputs are 0.
- R10: Every access is acknowledged with reg_ack=1 in the second cycle after the request cycle. A write acknowledge carries reg_rdata 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | CPU access strobe, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Word offset within the group window |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid with reg_ack |
| reg_ack | output | 1 | Access completion |
| sub_sel | output | 1 | Forwarded access strobe |
| sub_wr | output | 1 | Forwarded write flag |
| sub_addr | output | ADDR_W | Forwarded address |
| sub_wdata | output | DATA_W | Forwarded write data |
| sub_rdata | input | DATA_W | Submodule read data, valid while sub_sel |
| sub_irq | input | NUM_SUB | Per-submodule interrupt request |
| sub_lvl | input | NUM_SUB*LVL_W | Per-submodule request level, packed |
| sub_vlo | input | NUM_SUB*VLO_W | Per-submodule 6-bit vector code, packed |
| freeze | input | 1 | Debug freeze request |
| run_en | output | 1 | Global run enable for the submodules |
| irq_lvl_o | output | LVL_W | Level of the winning request, 0 if none |
| iack_valid | input | 1 | Interrupt acknowledge cycle |
| iack_lvl | input | LVL_W | Acknowledged level |
| iack_arb | input | ARB_W | Acknowledged arbitration number |
| iack_resp | output | 1 | Block answers the acknowledge |
| iack_lvl_o | output | LVL_W | Returned level |
| iack_arb_o | output | ARB_W | Returned arbitration number |
| iack_vec | output | VLO_W+2 | Returned vector number |

## Verification
The register write path and the acknowledge path can meet in one cycle. A CPU write that changes the vector base can be sampled at the same edge as an acknowledge. The bench provokes this by driving both in one cycle. It expects the answer to carry the old base, and the next acknowledge and a readback to show the new one. The stop write and a freeze change can also land together. That case is judged from run_en in the cycle after the write takes effect.

// File: rtl/tmr_biu_pkg.sv
package tmr_biu_pkg;
  localparam int          CFG_W     = 16;
  localparam logic [15:0] CFG_RST   = 16'h1800;
  localparam logic [15:0] CFG_WMASK = 16'hDF21;
  localparam int          B_STOP    = 15;
  localparam int          B_FRZ     = 14;
  localparam int          B_VB_HI   = 12;
  localparam int          B_VB_LO   = 11;
  localparam int          B_ARB_HI  = 10;
  localparam int          B_ARB_LO  = 8;

  typedef struct packed {
    logic       stop;
    logic       frz;
    logic [1:0] vbase;
    logic [2:0] arb;
  } cfg_view_t;

  function automatic cfg_view_t view_cfg(input logic [CFG_W-1:0] r);
    cfg_view_t v;
    v.stop  = r[B_STOP];
    v.frz   = r[B_FRZ];
    v.vbase = r[B_VB_HI:B_VB_LO];
    v.arb   = r[B_ARB_HI:B_ARB_LO];
    return v;
  endfunction
endpackage

// File: rtl/tmr_biu_regs.sv
module tmr_biu_regs
  import tmr_biu_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int LOCAL_SLOTS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_sel,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  output logic                    reg_ack,
  output logic                    sub_sel,
  output logic                    sub_wr,
  output logic [ADDR_W-1:0]       sub_addr,
  output logic [DATA_W-1:0]       sub_wdata,
  input  logic [DATA_W-1:0]       sub_rdata,
  output logic [CFG_W-1:0]        cfg_q
);
  localparam logic [ADDR_W-1:0] LOCAL_LIM = ADDR_W'(LOCAL_SLOTS);
  localparam logic [ADDR_W-1:0] CFG_OFS   = '0;

  logic              in_local;
  logic              cfg_we;
  logic              req_v, req_wr, req_local, req_cfg;
  logic [DATA_W-1:0] local_rd;

  assign in_local = reg_addr < LOCAL_LIM;
  assign cfg_we   = reg_sel && reg_wr && (reg_addr == CFG_OFS);

  // configuration register: only the implemented bits take the write
  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= CFG_RST;
    else if (cfg_we) cfg_q <= reg_wdata[CFG_W-1:0] & CFG_WMASK;
  end

  // stage 1: capture request and forward non-local accesses
  always_ff @(posedge clk) begin
    if (rst) begin
      req_v     <= 1'b0;
      req_wr    <= 1'b0;
      req_local <= 1'b0;
      req_cfg   <= 1'b0;
      sub_sel   <= 1'b0;
      sub_wr    <= 1'b0;
      sub_addr  <= '0;
      sub_wdata <= '0;
    end else begin
      req_v     <= reg_sel;
      req_wr    <= reg_wr;
      req_local <= in_local;
      req_cfg   <= reg_addr == CFG_OFS;
      sub_sel   <= reg_sel && !in_local;
      sub_wr    <= reg_sel && reg_wr && !in_local;
      sub_addr  <= reg_sel ? reg_addr : '0;
      sub_wdata <= (reg_sel && reg_wr) ? reg_wdata : '0;
    end
  end

  // reserved local slots read as zero
  assign local_rd = req_cfg ? DATA_W'(cfg_q) : '0;

  // stage 2: completion
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_ack   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      reg_ack <= req_v;
      if (!req_v || req_wr) reg_rdata <= '0;
      else if (req_local)   reg_rdata <= local_rd;
      else                  reg_rdata <= sub_rdata;
    end
  end
endmodule

// File: rtl/tmr_biu_arb.sv
module tmr_biu_arb #(
  parameter int NUM_SUB = 8,
  parameter int LVL_W   = 3,
  parameter int VLO_W   = 6
) (
  input  logic [NUM_SUB-1:0]       sub_irq,
  input  logic [NUM_SUB*LVL_W-1:0] sub_lvl,
  input  logic [NUM_SUB*VLO_W-1:0] sub_vlo,
  output logic                     win_any,
  output logic [LVL_W-1:0]         win_lvl,
  output logic [VLO_W-1:0]         win_vlo
);
  // scan from the top down so the lowest pending index is written last
  always_comb begin
    win_any = 1'b0;
    win_lvl = '0;
    win_vlo = '0;
    for (int i = NUM_SUB - 1; i >= 0; i--) begin
      if (sub_irq[i]) begin
        win_any = 1'b1;
        win_lvl = sub_lvl[i*LVL_W +: LVL_W];
        win_vlo = sub_vlo[i*VLO_W +: VLO_W];
      end
    end
  end
endmodule

// File: rtl/tmr_biu_iack.sv
module tmr_biu_iack #(
  parameter int LVL_W = 3,
  parameter int ARB_W = 3,
  parameter int VLO_W = 6,
  parameter int VEC_W = VLO_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_any,
  input  logic [LVL_W-1:0] win_lvl,
  input  logic [VLO_W-1:0] win_vlo,
  input  logic [1:0]       vbase,
  input  logic [ARB_W-1:0] arb_id,
  input  logic             iack_valid,
  input  logic [LVL_W-1:0] iack_lvl,
  input  logic [ARB_W-1:0] iack_arb,
  output logic [LVL_W-1:0] irq_lvl_o,
  output logic             iack_resp,
  output logic [LVL_W-1:0] iack_lvl_o,
  output logic [ARB_W-1:0] iack_arb_o,
  output logic [VEC_W-1:0] iack_vec
);
  logic hit;
  assign hit = iack_valid && win_any && (win_lvl != '0) &&
               (iack_lvl == win_lvl) && (iack_arb == arb_id);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lvl_o  <= '0;
      iack_resp  <= 1'b0;
      iack_lvl_o <= '0;
      iack_arb_o <= '0;
      iack_vec   <= '0;
    end else begin
      irq_lvl_o  <= win_any ? win_lvl : '0;
      iack_resp  <= hit;
      iack_lvl_o <= hit ? win_lvl : '0;
      iack_arb_o <= hit ? arb_id : '0;
      iack_vec   <= hit ? {vbase, win_vlo} : '0;
    end
  end
endmodule

// File: rtl/tmr_biu_run.sv
module tmr_biu_run (
  input  logic clk,
  input  logic rst,
  input  logic stop,
  input  logic frz,
  input  logic freeze,
  output logic run_en
);
  always_ff @(posedge clk) begin
    if (rst) run_en <= 1'b1;
    else     run_en <= !stop && !(frz && freeze);
  end
endmodule

// File: rtl/tmr_bus_iface.sv
module tmr_bus_iface
  import tmr_biu_pkg::*;
#(
  parameter int NUM_SUB     = 8,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int LVL_W       = 3,
  parameter int ARB_W       = 3,
  parameter int VLO_W       = 6,
  parameter int LOCAL_SLOTS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_sel,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  output logic                     reg_ack,
  output logic                     sub_sel,
  output logic                     sub_wr,
  output logic [ADDR_W-1:0]        sub_addr,
  output logic [DATA_W-1:0]        sub_wdata,
  input  logic [DATA_W-1:0]        sub_rdata,
  input  logic [NUM_SUB-1:0]       sub_irq,
  input  logic [NUM_SUB*LVL_W-1:0] sub_lvl,
  input  logic [NUM_SUB*VLO_W-1:0] sub_vlo,
  input  logic                     freeze,
  output logic                     run_en,
  output logic [LVL_W-1:0]         irq_lvl_o,
  input  logic                     iack_valid,
  input  logic [LVL_W-1:0]         iack_lvl,
  input  logic [ARB_W-1:0]         iack_arb,
  output logic                     iack_resp,
  output logic [LVL_W-1:0]         iack_lvl_o,
  output logic [ARB_W-1:0]         iack_arb_o,
  output logic [VLO_W+1:0]         iack_vec
);
  localparam int VEC_W = VLO_W + 2;

  logic [CFG_W-1:0] cfg_q;
  cfg_view_t        cv;
  logic             win_any;
  logic [LVL_W-1:0] win_lvl;
  logic [VLO_W-1:0] win_vlo;

  assign cv = view_cfg(cfg_q);

  tmr_biu_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCAL_SLOTS(LOCAL_SLOTS)) u_regs (
    .clk(clk), .rst(rst),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_ack(reg_ack),
    .sub_sel(sub_sel), .sub_wr(sub_wr), .sub_addr(sub_addr), .sub_wdata(sub_wdata),
    .sub_rdata(sub_rdata), .cfg_q(cfg_q)
  );

  tmr_biu_run u_run (
    .clk(clk), .rst(rst), .stop(cv.stop), .frz(cv.frz), .freeze(freeze), .run_en(run_en)
  );

  tmr_biu_arb #(.NUM_SUB(NUM_SUB), .LVL_W(LVL_W), .VLO_W(VLO_W)) u_arb (
    .sub_irq(sub_irq), .sub_lvl(sub_lvl), .sub_vlo(sub_vlo),
    .win_any(win_any), .win_lvl(win_lvl), .win_vlo(win_vlo)
  );

  tmr_biu_iack #(.LVL_W(LVL_W), .ARB_W(ARB_W), .VLO_W(VLO_W), .VEC_W(VEC_W)) u_iack (
    .clk(clk), .rst(rst),
    .win_any(win_any), .win_lvl(win_lvl), .win_vlo(win_vlo),
    .vbase(cv.vbase), .arb_id(ARB_W'(cv.arb)),
    .iack_valid(iack_valid), .iack_lvl(iack_lvl), .iack_arb(iack_arb),
    .irq_lvl_o(irq_lvl_o), .iack_resp(iack_resp), .iack_lvl_o(iack_lvl_o),
    .iack_arb_o(iack_arb_o), .iack_vec(iack_vec)
  );
endmodule

// File: rtl/tmr_biu_chk.sv
module tmr_biu_chk #(
  parameter int ADDR_W      = 6,
  parameter int VEC_W       = 8,
  parameter int LOCAL_SLOTS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       cfg_q,
  input logic              freeze,
  input logic              run_en,
  input logic              reg_sel,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              sub_sel,
  input logic              iack_valid,
  input logic              iack_resp,
  input logic [VEC_W-1:0]  iack_vec
);
  // R2: unimplemented bits never hold a 1
  p_cfg_mask_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_q & ~16'hDF21) == 16'h0);

  // R4: stop forces the run enable low
  p_stop_halts_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_q[15] |=> !run_en);

  // R6: honoured freeze forces the run enable low
  p_frz_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[14] && freeze) |=> !run_en);

  // R6: with neither stop nor honoured freeze, the group runs
  p_run_free_r6: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q[15] && !(cfg_q[14] && freeze)) |=> run_en);

  // R5: a forwarded strobe follows a non-local request
  p_fwd_src_r5: assert property (@(posedge clk) disable iff (rst)
    sub_sel |-> ($past(reg_sel) && ($past(reg_addr) >= ADDR_W'(LOCAL_SLOTS))));

  // R7: vector base comes from the register value before the acknowledge edge
  p_vec_base_r7: assert property (@(posedge clk) disable iff (rst)
    iack_resp |-> (iack_vec[VEC_W-1 -: 2] == $past(cfg_q[12:11])));

  // R9: a response always follows an acknowledge cycle
  p_resp_cause_r9: assert property (@(posedge clk) disable iff (rst)
    iack_resp |-> $past(iack_valid));

  // R9: outputs are quiet when not answering
  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !iack_resp |-> (iack_vec == '0));
endmodule

bind tmr_bus_iface tmr_biu_chk #(
  .ADDR_W(ADDR_W), .VEC_W(VLO_W + 2), .LOCAL_SLOTS(LOCAL_SLOTS)
) u_chk (
  .clk(clk), .rst(rst), .cfg_q(cfg_q), .freeze(freeze), .run_en(run_en),
  .reg_sel(reg_sel), .reg_addr(reg_addr), .sub_sel(sub_sel),
  .iack_valid(iack_valid), .iack_resp(iack_resp), .iack_vec(iack_vec)
);

// File: tb/sim_tmr_bus_iface.sv
`timescale 1ns/1ps
module sim_tmr_bus_iface;
  localparam int NUM_SUB = 8, ADDR_W = 6, DATA_W = 16, LVL_W = 3, ARB_W = 3, VLO_W = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_sel = 0, reg_wr = 0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0, reg_rdata, sub_wdata, sub_rdata;
  logic reg_ack, sub_sel, sub_wr, freeze = 0, run_en;
  logic [ADDR_W-1:0] sub_addr;
  logic [NUM_SUB-1:0] sub_irq = '0;
  logic [NUM_SUB*LVL_W-1:0] sub_lvl;
  logic [NUM_SUB*VLO_W-1:0] sub_vlo;
  logic [LVL_W-1:0] irq_lvl_o, iack_lvl = '0, iack_lvl_o;
  logic [ARB_W-1:0] iack_arb = '0, iack_arb_o;
  logic iack_valid = 0, iack_resp;
  logic [VLO_W+1:0] iack_vec;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] rq_exp[$]; string rq_tag[$];
  logic [15:0] iq_exp[$]; string iq_tag[$];

  always #2.5 clk = ~clk;

  // submodule model: read data derived from address
  assign sub_rdata = sub_sel ? (16'hA500 | 16'(sub_addr)) : 16'h0;

  // per-submodule level (i%7)+1 and vector code i*5+3
  always_comb begin
    for (int i = 0; i < NUM_SUB; i++) begin
      sub_lvl[i*LVL_W +: LVL_W] = LVL_W'((i % 7) + 1);
      sub_vlo[i*VLO_W +: VLO_W] = VLO_W'(i * 5 + 3);
    end
  end

  tmr_bus_iface u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as the design completes them
  always @(negedge clk) begin
    if (!rst) begin
      if (reg_ack) begin
        if (rq_exp.size() == 0) check(0, "R10 unexpected ack", 32'(reg_rdata), 0);
        else begin
          logic [15:0] e; string t;
          e = rq_exp.pop_front(); t = rq_tag.pop_front();
          check(reg_rdata == e, t, 32'(reg_rdata), 32'(e));
        end
      end
      if (iack_resp) begin
        logic [15:0] got;
        got = {iack_vec, 2'b0, iack_lvl_o, iack_arb_o};
        if (iq_exp.size() == 0) check(0, "R9 unexpected response", 32'(got), 0);
        else begin
          logic [15:0] e; string t;
          e = iq_exp.pop_front(); t = iq_tag.pop_front();
          check(got == e, t, 32'(got), 32'(e));
        end
      end
    end
  end

  task automatic acc(input bit wr, input int addr, input logic [15:0] d,
                     input logic [15:0] exp, input string tag);
    rq_exp.push_back(wr ? 16'h0 : exp); rq_tag.push_back(tag);
    @(negedge clk);
    reg_sel = 1; reg_wr = wr; reg_addr = ADDR_W'(addr); reg_wdata = d;
    @(posedge clk); #1;
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic chk_run(input bit exp, input string tag);
    @(posedge clk); @(negedge clk);
    check(run_en == exp, tag, 32'(run_en), 32'(exp));
  endtask

  task automatic iack(input int lvl, input int arb, input bit exp_resp,
                      input logic [7:0] ev, input string tag);
    if (exp_resp) begin
      iq_exp.push_back({ev, 2'b0, LVL_W'(lvl), ARB_W'(arb)}); iq_tag.push_back(tag);
    end
    @(negedge clk);
    iack_valid = 1; iack_lvl = LVL_W'(lvl); iack_arb = ARB_W'(arb);
    @(posedge clk); #1;
    iack_valid = 0;
    @(negedge clk);
    if (!exp_resp) check(!iack_resp && iack_vec == 0, tag, 32'(iack_vec), 0);
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(run_en == 1, "R1 run_en after reset", 32'(run_en), 1);
    check(irq_lvl_o == 0, "R1 irq_lvl_o after reset", 32'(irq_lvl_o), 0);
    check(iack_resp == 0, "R9 no response after reset", 32'(iack_resp), 0);
    acc(0, 0, 0, 16'h1800, "R1 reset value");

    // R2 mask, R4 stop
    acc(1, 0, 16'hFFFF, 0, "R10 write ack");
    chk_run(0, "R4 stop halts");
    acc(0, 0, 0, 16'hDF21, "R2 writable mask");
    // R5 forwarding while stopped
    acc(0, 9, 0, 16'hA509, "R5 sub read while stopped");
    acc(1, 20, 16'h1234, 0, "R10 sub write ack");
    // R3 reserved slots
    acc(1, 2, 16'hFFFF, 0, "R10 write ack");
    acc(1, 1, 16'h0000, 0, "R10 write ack");
    acc(0, 2, 0, 16'h0, "R3 offset 2 reads zero");
    acc(0, 3, 0, 16'h0, "R3 offset 3 reads zero");
    acc(0, 0, 0, 16'hDF21, "R3 cfg unchanged");
    chk_run(0, "R4 stays stopped");
    acc(1, 0, 16'h0000, 0, "R10 write ack");
    chk_run(1, "R4 stop cleared");
    acc(0, 0, 0, 16'h0, "R2 write zero");

    // R6 freeze
    @(negedge clk); freeze = 1;
    chk_run(1, "R6 freeze ignored");
    acc(1, 0, 16'h4000, 0, "R10 write ack");
    chk_run(0, "R6 freeze honoured");
    @(negedge clk); freeze = 0;
    chk_run(1, "R6 freeze released");

    // R7 four vector bases, sub 3 (level 4, code 18)
    @(negedge clk); sub_irq = 8'b0000_1000;
    for (int b = 0; b < 4; b++) begin
      acc(1, 0, 16'((b << 11) | (5 << 8)), 0, "R10 write ack");
      iack(4, 5, 1, {2'(b), 6'd18}, "R7 vector base");
    end

    // R8 priority among subs 2,5,6
    @(negedge clk); sub_irq = 8'b0110_0100;
    @(posedge clk); @(negedge clk);
    check(irq_lvl_o == 3, "R8 winner level", 32'(irq_lvl_o), 3);
    iack(3, 5, 1, {2'b11, 6'd13}, "R8 winner vector");
    // R9 mismatches
    iack(6, 5, 0, 0, "R9 wrong level");
    iack(3, 2, 0, 0, "R9 wrong arbitration");
    @(negedge clk); sub_irq = '0;
    @(posedge clk); @(negedge clk);
    check(irq_lvl_o == 0, "R8 nothing pending", 32'(irq_lvl_o), 0);
    iack(3, 5, 0, 0, "R9 nothing pending");

    // R7 same-cycle base write and acknowledge
    @(negedge clk); sub_irq = 8'b0000_0010;
    acc(1, 0, 16'h0500, 0, "R10 write ack");
    rq_exp.push_back(16'h0); rq_tag.push_back("R10 write ack");
    iq_exp.push_back({2'b00, 6'd8, 2'b0, 3'd2, 3'd5}); iq_tag.push_back("R7 old base same cycle");
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_addr = '0; reg_wdata = 16'h1D00;
    iack_valid = 1; iack_lvl = 3'd2; iack_arb = 3'd5;
    @(posedge clk); #1;
    reg_sel = 0; reg_wr = 0; iack_valid = 0;
    iack(2, 5, 1, {2'b11, 6'd8}, "R7 new base after write");
    acc(0, 0, 0, 16'h1D00, "R7 base readback");

    drain();
    check(rq_exp.size() == 0 && iq_exp.size() == 0, "R10 all items completed",
          32'(rq_exp.size() + iq_exp.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule